// File: doc/BRIEF.md
# DDR Memory Calibration Stage Sequencer

This block is the top-level controller that takes a DDR2 or DDR3 memory PHY from reset to a calibrated state. Each calibration step is carried out by a separate engine outside the block. Every engine is reached through a start pulse, a done input and an error input. The sequencer only decides which engine runs next, reruns engines where the flow needs it, and watches for errors. It does not perform any delay-tap arithmetic, pattern generation or command timing itself.

Once reset is released, the block runs the mode-register initialization engine first. That engine programs burst length, read/write CAS latency and additive latency, and it can never cause a failure. The block then steps through the calibration stages in a fixed order with these exceptions:

- Write leveling runs only for DDR3.
- Write leveling runs again after write-clock delay centering.
- When write calibration reports early writes, the block goes back through write leveling and asks for one more memory clock of write delay each time, up to two cycles.

The run ends either in a sticky complete state or in a sticky fail state.

Top module: `memcal_seq`

## Requirements
- R1: While rst_ni is low, stage_o is 0, start_o is all zero, and wr_extra_o, complete_o and fail_o are 0. In the first cycle after reset is released, stage_o becomes 1 (init) and start_o[0] pulses.
- R2: Engine indices are: init 0, phase lock 1, strobe-found 2, initial read leveling 3, write leveling 4, register-pattern read leveling 5, write-clock delay centering 6, write calibration 7, PRBS read leveling 8. A stage is entered with exactly one start_o bit high for one cycle, in the first cycle that stage_o shows the stage. start_o is zero in every other cycle.
- R3: done_i is sampled only for the active engine. The next stage appears on stage_o one cycle after that done_i is high. done_i bits of inactive engines have no effect.
- R4: err_i[0] never causes a failure. It is ignored during the init stage (stage_o 1).
- R5: Stage codes are: 0 idle, 1 init, 2 phase lock, 3 strobe-found, 4 initial read leveling, 5 first write leveling, 6 register-pattern read leveling, 7 write-clock delay centering, 8 repeat write leveling, 9 write calibration, 10 PRBS read leveling, 11 complete, 12 fail. For DDR3 (ddr3_i=1) with no early writes, the order is 1,2,3,4,5,6,7,8,9,10,11.
- R6: With ddr3_i=0, both write-leveling stages are skipped. Stage 4 goes to 6, and stage 7 goes to 9. start_o[4] never pulses.
- R7: With DDR3, when write-clock delay centering finishes, the block enters stage 8 (write leveling, start_o[4]). When stage 8 finishes, it enters stage 9.
- R8: early_i is sampled only together with done_i[7] in stage 9.
  - The first and second early indications each raise wr_extra_o by one (to 1, then 2). The block then re-enters stage 8 for DDR3, or stage 9 for DDR2, and pulses the matching start bit.
  - A third early indication moves the block to fail and leaves wr_extra_o at 2.
- R9: An error from the active engine in any stage other than init moves the block to stage 12 the next cycle, with fail_o high. The block stays there until reset, whatever done_i and err_i do.
- R10: When done_i[8] is seen in stage 10, stage 11 is entered with complete_o high. The block stays there until reset, and errors have no effect there. An error and a done in the same cycle give fail. complete_o and fail_o are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ddr3_i | input | 1 | Memory type: 1 = DDR3, 0 = DDR2 |
| done_i | input | 9 | Per-engine done |
| err_i | input | 9 | Per-engine error |
| early_i | input | 1 | Write calibration saw early writes (qualified by done_i[7]) |
| start_o | output | 9 | Per-engine single-cycle start pulse |
| stage_o | output | 4 | Current stage code |
| wr_extra_o | output | 2 | Extra write-delay cycles requested |
| complete_o | output | 1 | Calibration complete (sticky) |
| fail_o | output | 1 | Calibration failed (sticky) |

## Verification
All outputs come from registers, so every response to a done, error or early indication is due exactly one clock later. stage_o, the start pulse, wr_extra_o, complete_o and fail_o all move together in that cycle.

The driver applies each stimulus at a falling edge and queues the outputs expected after the next rising edge. The monitor takes one queued item 2 ns after each rising edge and compares it, so every check lands in the single cycle in which its result is due.

The bench also checks that the start pulse drops in the following cycle, and that ignored inputs leave stage_o unchanged one cycle later.

// File: rtl/memcal_pkg.sv
package memcal_pkg;
  localparam int NUM_ENG = 9;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_INIT    = 4'd1,
    ST_PLOCK   = 4'd2,
    ST_SFIND   = 4'd3,
    ST_RDLVL   = 4'd4,
    ST_WRLVL_A = 4'd5,
    ST_MPRLV   = 4'd6,
    ST_WCKDLY  = 4'd7,
    ST_WRLVL_B = 4'd8,
    ST_WRCAL   = 4'd9,
    ST_PRBS    = 4'd10,
    ST_DONE    = 4'd11,
    ST_FAIL    = 4'd12
  } stage_e;

  // engine driven by a stage, -1 when none
  function automatic int eng_of(stage_e s);
    case (s)
      ST_INIT:               return 0;
      ST_PLOCK:              return 1;
      ST_SFIND:              return 2;
      ST_RDLVL:              return 3;
      ST_WRLVL_A, ST_WRLVL_B: return 4;
      ST_MPRLV:              return 5;
      ST_WCKDLY:             return 6;
      ST_WRCAL:              return 7;
      ST_PRBS:               return 8;
      default:               return -1;
    endcase
  endfunction
endpackage

// File: rtl/memcal_next.sv
module memcal_next
  import memcal_pkg::*;
#(
  parameter int MAX_EARLY = 2,
  localparam int EW = $clog2(MAX_EARLY + 1)
) (
  input  stage_e               state_q_i,
  input  logic                 ddr3_i,
  input  logic [NUM_ENG-1:0]   done_i,
  input  logic [NUM_ENG-1:0]   err_i,
  input  logic                 early_i,
  input  logic [EW-1:0]        early_cnt_i,
  output stage_e               state_d_o,
  output logic                 enter_o,
  output logic                 early_inc_o
);
  logic [NUM_ENG-1:0] sel;
  logic act_done, act_err, adv;

  always_comb begin
    for (int k = 0; k < NUM_ENG; k++) sel[k] = (eng_of(state_q_i) == k);
  end

  assign act_done = |(done_i & sel);
  assign act_err  = |(err_i & sel);

  always_comb begin
    state_d_o   = state_q_i;
    adv         = 1'b0;
    early_inc_o = 1'b0;
    case (state_q_i)
      ST_IDLE: begin
        state_d_o = ST_INIT;
        adv       = 1'b1;
      end
      ST_DONE, ST_FAIL: ;
      default: begin
        if (act_err && state_q_i != ST_INIT) begin
          state_d_o = ST_FAIL;
        end else if (act_done) begin
          adv = 1'b1;
          case (state_q_i)
            ST_INIT:    state_d_o = ST_PLOCK;
            ST_PLOCK:   state_d_o = ST_SFIND;
            ST_SFIND:   state_d_o = ST_RDLVL;
            ST_RDLVL:   state_d_o = ddr3_i ? ST_WRLVL_A : ST_MPRLV;
            ST_WRLVL_A: state_d_o = ST_MPRLV;
            ST_MPRLV:   state_d_o = ST_WCKDLY;
            ST_WCKDLY:  state_d_o = ddr3_i ? ST_WRLVL_B : ST_WRCAL;
            ST_WRLVL_B: state_d_o = ST_WRCAL;
            ST_WRCAL: begin
              if (!early_i) begin
                state_d_o = ST_PRBS;
              end else if (early_cnt_i < EW'(MAX_EARLY)) begin
                early_inc_o = 1'b1;
                state_d_o   = ddr3_i ? ST_WRLVL_B : ST_WRCAL;
              end else begin
                state_d_o = ST_FAIL;
              end
            end
            ST_PRBS:    state_d_o = ST_DONE;
            default:    state_d_o = state_q_i;
          endcase
        end
      end
    endcase
  end

  // rerunning the same stage (DDR2 early write) still re-enters it
  assign enter_o = adv && (eng_of(state_d_o) >= 0);
endmodule

// File: rtl/memcal_start.sv
module memcal_start
  import memcal_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enter_i,
  input  stage_e             state_d_i,
  output logic [NUM_ENG-1:0] start_o
);
  logic [NUM_ENG-1:0] hit;

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_hit
    assign hit[k] = (eng_of(state_d_i) == k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_o <= '0;
    else         start_o <= enter_i ? hit : '0;
  end
endmodule

// File: rtl/memcal_early_ctr.sv
module memcal_early_ctr #(
  parameter int EW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [EW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/memcal_seq.sv
module memcal_seq
  import memcal_pkg::*;
#(
  parameter int MAX_EARLY = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ddr3_i,
  input  logic [8:0]                       done_i,
  input  logic [8:0]                       err_i,
  input  logic                             early_i,
  output logic [8:0]                       start_o,
  output logic [3:0]                       stage_o,
  output logic [$clog2(MAX_EARLY+1)-1:0]   wr_extra_o,
  output logic                             complete_o,
  output logic                             fail_o
);
  localparam int EW = $clog2(MAX_EARLY + 1);

  stage_e state_q, state_d;
  logic   enter, early_inc;

  memcal_next #(.MAX_EARLY(MAX_EARLY)) u_next (
    .state_q_i   (state_q),
    .ddr3_i      (ddr3_i),
    .done_i      (done_i),
    .err_i       (err_i),
    .early_i     (early_i),
    .early_cnt_i (wr_extra_o),
    .state_d_o   (state_d),
    .enter_o     (enter),
    .early_inc_o (early_inc)
  );

  memcal_start u_start (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enter_i   (enter),
    .state_d_i (state_d),
    .start_o   (start_o)
  );

  memcal_early_ctr #(.EW(EW)) u_early (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (early_inc),
    .cnt_o  (wr_extra_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign stage_o    = state_q;
  assign complete_o = (state_q == ST_DONE);
  assign fail_o     = (state_q == ST_FAIL);
endmodule

// File: rtl/memcal_seq_chk.sv
module memcal_seq_chk #(
  parameter int MAX_EARLY = 2,
  localparam int EW = $clog2(MAX_EARLY + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ddr3_i,
  input logic [8:0]    done_i,
  input logic [8:0]    err_i,
  input logic [8:0]    start_o,
  input logic [3:0]    stage_o,
  input logic [EW-1:0] wr_extra_o,
  input logic          complete_o,
  input logic          fail_o
);
  // R2
  start_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));

  // R4
  init_err_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 4'd1 && err_i[0] && !done_i[0]) |=> (stage_o == 4'd1 && !fail_o));

  // R6
  ddr2_no_wrlvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ddr3_i |-> !start_o[4]);

  // R8
  extra_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_extra_o <= EW'(MAX_EARLY));

  // R9
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> (fail_o && start_o == '0));

  // R10
  complete_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o |=> (complete_o && !fail_o));

  // R10
  excl_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(complete_o && fail_o));
endmodule

bind memcal_seq memcal_seq_chk #(.MAX_EARLY(MAX_EARLY)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ddr3_i     (ddr3_i),
  .done_i     (done_i),
  .err_i      (err_i),
  .start_o    (start_o),
  .stage_o    (stage_o),
  .wr_extra_o (wr_extra_o),
  .complete_o (complete_o),
  .fail_o     (fail_o)
);

// File: tb/memcal_seq_bench.sv
`timescale 1ns/1ps
module memcal_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ddr3_i = 1'b1;
  logic [8:0] done_i = '0;
  logic [8:0] err_i = '0;
  logic       early_i = 1'b0;
  logic [8:0] start_o;
  logic [3:0] stage_o;
  logic [1:0] wr_extra_o;
  logic       complete_o, fail_o;

  int checks = 0;
  int errors = 0;
  int ex_extra = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] stage;
    logic [8:0] start;
    logic [1:0] extra;
    logic       cmp;
    logic       fl;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk_i = ~clk_i;

  memcal_seq u_memcal_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ddr3_i(ddr3_i), .done_i(done_i),
    .err_i(err_i), .early_i(early_i), .start_o(start_o), .stage_o(stage_o),
    .wr_extra_o(wr_extra_o), .complete_o(complete_o), .fail_o(fail_o)
  );

  function automatic logic [8:0] b(int k);
    return 9'(1) << k;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (stage_o !== e.stage || start_o !== e.start || wr_extra_o !== e.extra ||
        complete_o !== e.cmp || fail_o !== e.fl) begin
      errors++;
      $display("FAIL %s stage=%0d/%0d start=%b/%b extra=%0d/%0d cmp=%b/%b fail=%b/%b",
               e.tag, stage_o, e.stage, start_o, e.start, wr_extra_o, e.extra,
               complete_o, e.cmp, fail_o, e.fl);
    end
  endtask

  function automatic exp_t mk(int stg, int eng, string tag);
    exp_t e;
    e.stage = 4'(stg);
    e.start = (eng >= 0) ? b(eng) : 9'd0;
    e.extra = 2'(ex_extra);
    e.cmp   = (stg == 11);
    e.fl    = (stg == 12);
    e.tag   = tag;
    return e;
  endfunction

  // driver: apply one cycle of stimulus, queue the state due after the next rising edge
  task automatic step(logic [8:0] d, logic [8:0] e, logic ea, int stg, int eng, string tag);
    @(negedge clk_i);
    done_i = d; err_i = e; early_i = ea;
    sb_q.push_back(mk(stg, eng, tag));
  endtask

  task automatic start_run(logic ddr3);
    @(negedge clk_i);
    rst_ni = 1'b0; ddr3_i = ddr3; done_i = '0; err_i = '0; early_i = 1'b0;
    ex_extra = 0;
    repeat (2) @(negedge clk_i);
    compare(mk(0, -1, "R1"));
    rst_ni = 1'b1;
    sb_q.push_back(mk(1, 0, "R1"));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // DDR3 full flow with two early-write returns
    start_run(1'b1);
    step('0, b(0), 0, 1, -1, "R4");
    step(b(0), '0, 0, 2, 1, "R5");
    step(b(5), '0, 0, 2, -1, "R3");
    step('0, '0, 0, 2, -1, "R2");
    step(b(1), '0, 0, 3, 2, "R5");
    step(b(2), '0, 0, 4, 3, "R5");
    step(b(3), '0, 0, 5, 4, "R5");
    step(b(4), '0, 0, 6, 5, "R5");
    step(b(5), '0, 0, 7, 6, "R5");
    step(b(6), '0, 0, 8, 4, "R7");
    step(b(4), '0, 0, 9, 7, "R7");
    step('0, '0, 1, 9, -1, "R8");
    ex_extra = 1;
    step(b(7), '0, 1, 8, 4, "R8");
    step(b(4), '0, 0, 9, 7, "R8");
    ex_extra = 2;
    step(b(7), '0, 1, 8, 4, "R8");
    step(b(4), '0, 0, 9, 7, "R8");
    step(b(7), '0, 0, 10, 8, "R5");
    step(b(8), '0, 0, 11, -1, "R10");
    step('1, '1, 0, 11, -1, "R10");

    // DDR2 flow: leveling skipped, third early write fails
    start_run(1'b0);
    step(b(0), '0, 0, 2, 1, "R5");
    step(b(1), '0, 0, 3, 2, "R5");
    step(b(2), '0, 0, 4, 3, "R5");
    step(b(3), '0, 0, 6, 5, "R6");
    step(b(5), '0, 0, 7, 6, "R6");
    step(b(6), '0, 0, 9, 7, "R6");
    ex_extra = 1;
    step(b(7), '0, 1, 9, 7, "R8");
    ex_extra = 2;
    step(b(7), '0, 1, 9, 7, "R8");
    step(b(7), '0, 1, 12, -1, "R8");
    step('1, '0, 0, 12, -1, "R9");

    // error handling
    start_run(1'b1);
    step(b(0), '0, 0, 2, 1, "R5");
    step('0, b(4), 0, 2, -1, "R3");
    step(b(1), b(1), 0, 12, -1, "R10");
    step(b(2), '0, 0, 12, -1, "R9");
    start_run(1'b1);
    step(b(0), '0, 0, 2, 1, "R5");
    step(b(1), '0, 0, 3, 2, "R5");
    step('0, b(2), 0, 12, -1, "R9");

    @(posedge clk_i);
    #3;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule